// File: doc/BRIEF.md
# Warp Thread-Mask and Launch Controller

This block keeps the control state of every warp in a small SIMT core. For each warp it holds a lane mask, a live-lane count, a launched flag, a start PC and a privilege bit. A scheduler reads these values directly. A running warp can issue two kinds of command. A mask command shrinks or grows the warp to its first N lanes. A launch command starts a group of other warps at one shared PC.

A mask command takes a count N from operand A. It leaves lanes 0 to N-1 enabled and turns off every other lane. With a count of zero the issuing warp retires. A launch command takes a warp count from operand A and a PC from operand B. It starts warps 1 up to count-1. Each of those warps begins with only lane 0 enabled, a live-lane count of one, and the privilege bit in user mode. Warp 0 is never touched by a launch.

A command is honoured only when it comes from lane 0 of a warp that is currently launched. Counts that are too large are clamped to the hardware size, and a one-cycle error flag is raised. Every update happens on one clock edge, so the new state is visible in the following cycle.

Top module: `warp_ctl`

## Requirements
- R1: After reset, warp 0 is launched with lane mask 0001, live count 1 and supervisor mode (user bit 0), and its PC equals RESET_PC. Every other warp is not launched and has mask 0, count 0, user bit 0 and PC RESET_PC. Both error flags are 0.
- R2: A mask command (cmd_op = 0) with count N, where 1 <= N <= NUM_THREADS, sets the issuing warp's mask to lanes 0..N-1 only (mask value 2^N-1) and its count to N. The warp stays launched, and its PC and user bit do not change.
- R3: A mask command with count 0 clears the issuing warp's mask, count and launched flag.
- R4: A mask command with a count above NUM_THREADS sets every lane and a count of NUM_THREADS. It also raises err_thread_cnt for exactly the cycle after the command.
- R5: A launch command (cmd_op = 1) with count K takes its PC from operand B. Every warp w with 1 <= w < K receives mask 0001, count 1, user bit 1, the launched flag set, and that PC.
- R6: A launch command leaves warp 0, and every warp at or above K, unchanged.
- R7: A launch count above NUM_WARPS is clamped to NUM_WARPS, and err_warp_cnt is raised for exactly the cycle after the command.
- R8: A command issued with cmd_lane not equal to 0 changes no state and raises no error flag.
- R9: A command issued by a warp that is not launched changes no state and raises no error flag.
- R10: Each accepted command shows its effect in the cycle after the edge that samples it. With no accepted command, all warp state holds and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 = lane-mask command, 1 = warp-launch command |
| cmd_warp | input | $clog2(NUM_WARPS) | Issuing warp |
| cmd_lane | input | $clog2(NUM_THREADS) | Issuing lane; only lane 0 is honoured |
| opa | input | XLEN | Lane count or warp count |
| opb | input | XLEN | Launch PC |
| warp_mask | output | NUM_WARPS*NUM_THREADS | Lane masks, warp w at bits [w*NUM_THREADS +: NUM_THREADS] |
| warp_thread_cnt | output | NUM_WARPS*CNT_W | Live-lane counts, CNT_W = $clog2(NUM_THREADS+1) |
| warp_active | output | NUM_WARPS | Launched flag per warp |
| warp_pc | output | NUM_WARPS*XLEN | Start PC per warp |
| warp_user | output | NUM_WARPS | 1 = user mode, 0 = supervisor |
| err_thread_cnt | output | 1 | Pulse: mask count was clamped |
| err_warp_cnt | output | 1 | Pulse: launch count was clamped |

## Verification
Wrong internal state would reach the scheduler-facing outputs one cycle after the command that caused it. A bad prefix shows up as a mask whose population count differs from the count field. A bad launch range shows up as warp 0, or a warp at or above the count, changing its PC or mask. Because a retired warp must ignore every later command, a wrong launched flag also shows up one command later, when a command that should be dropped changes state anyway. The sweeps therefore compare every warp's full state after every command.

// File: rtl/warp_ctl_pkg.sv
package warp_ctl_pkg;
  typedef enum logic {
    OP_TMASK = 1'b0,
    OP_SPAWN = 1'b1
  } cmd_op_e;

  localparam int unsigned MAX_LANES = 64;

  // Lanes 0..n-1 set, all other lanes clear.
  function automatic logic [MAX_LANES-1:0] lane_prefix(input int unsigned n);
    logic [MAX_LANES-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < MAX_LANES; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/warp_cmd_dec.sv
module warp_cmd_dec #(
  parameter int NUM_WARPS   = 4,
  parameter int NUM_THREADS = 4,
  parameter int XLEN        = 32,
  localparam int WID_W  = $clog2(NUM_WARPS),
  localparam int TID_W  = $clog2(NUM_THREADS),
  localparam int CNT_W  = $clog2(NUM_THREADS + 1),
  localparam int SCNT_W = $clog2(NUM_WARPS + 1)
) (
  input  logic              cmd_valid,
  input  warp_ctl_pkg::cmd_op_e cmd_op,
  input  logic [WID_W-1:0]  cmd_warp,
  input  logic [TID_W-1:0]  cmd_lane,
  input  logic [XLEN-1:0]   opa,
  input  logic [NUM_WARPS-1:0] warp_active,
  output logic              tmc_go,
  output logic              spawn_go,
  output logic [CNT_W-1:0]  tmc_cnt,
  output logic [SCNT_W-1:0] spawn_cnt,
  output logic              tmc_over,
  output logic              spawn_over
);
  import warp_ctl_pkg::*;

  logic accept;

  // Only lane 0 of a launched warp may act.
  assign accept   = cmd_valid && (cmd_lane == '0) && warp_active[cmd_warp];
  assign tmc_go   = accept && (cmd_op == OP_TMASK);
  assign spawn_go = accept && (cmd_op == OP_SPAWN);

  assign tmc_over   = opa > XLEN'(NUM_THREADS);
  assign spawn_over = opa > XLEN'(NUM_WARPS);
  assign tmc_cnt    = tmc_over   ? CNT_W'(NUM_THREADS) : opa[CNT_W-1:0];
  assign spawn_cnt  = spawn_over ? SCNT_W'(NUM_WARPS)  : opa[SCNT_W-1:0];
endmodule

// File: rtl/warp_slot.sv
module warp_slot #(
  parameter int          NUM_THREADS = 4,
  parameter int          XLEN        = 32,
  parameter bit          BOOT        = 1'b0,
  parameter logic [31:0] RESET_PC    = 32'h0000_1000,
  localparam int CNT_W = $clog2(NUM_THREADS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tmc_hit,
  input  logic                   spawn_hit,
  input  logic [CNT_W-1:0]       tmc_cnt,
  input  logic [XLEN-1:0]        spawn_pc,
  output logic [NUM_THREADS-1:0] mask,
  output logic [CNT_W-1:0]       cnt,
  output logic                   active,
  output logic [XLEN-1:0]        pc,
  output logic                   user
);
  import warp_ctl_pkg::*;

  localparam logic [NUM_THREADS-1:0] LANE0 = {{(NUM_THREADS-1){1'b0}}, 1'b1};

  logic [MAX_LANES-1:0] pre_full;
  logic                 retire_evt;

  assign pre_full   = lane_prefix(int'(tmc_cnt));
  assign retire_evt = tmc_hit && (tmc_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask   <= BOOT ? LANE0 : '0;
      cnt    <= CNT_W'(BOOT);
      active <= BOOT;
      pc     <= XLEN'(RESET_PC);
      user   <= 1'b0;
    end else if (tmc_hit) begin
      mask <= pre_full[NUM_THREADS-1:0];
      cnt  <= tmc_cnt;
      if (retire_evt) active <= 1'b0;
    end else if (spawn_hit) begin
      mask   <= LANE0;
      cnt    <= CNT_W'(1);
      active <= 1'b1;
      pc     <= spawn_pc;
      user   <= 1'b1;
    end
  end

  AST_TMC_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    retire_evt |=> (!active && mask == '0)); // R3
  AST_TMC_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    tmc_hit |=> ($countones(mask) == int'($past(tmc_cnt)))); // R2
  AST_SPAWN_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_hit |=> (mask == LANE0 && active && user && cnt == CNT_W'(1))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmc_hit && !spawn_hit) |=> ($stable(mask) && $stable(pc) && $stable(active))); // R10
endmodule

// File: rtl/warp_ctl.sv
module warp_ctl #(
  parameter int          NUM_WARPS   = 4,
  parameter int          NUM_THREADS = 4,
  parameter int          XLEN        = 32,
  parameter logic [31:0] RESET_PC    = 32'h0000_1000,
  localparam int WID_W  = $clog2(NUM_WARPS),
  localparam int TID_W  = $clog2(NUM_THREADS),
  localparam int CNT_W  = $clog2(NUM_THREADS + 1),
  localparam int SCNT_W = $clog2(NUM_WARPS + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cmd_valid,
  input  logic                             cmd_op,
  input  logic [WID_W-1:0]                 cmd_warp,
  input  logic [TID_W-1:0]                 cmd_lane,
  input  logic [XLEN-1:0]                  opa,
  input  logic [XLEN-1:0]                  opb,
  output logic [NUM_WARPS*NUM_THREADS-1:0] warp_mask,
  output logic [NUM_WARPS*CNT_W-1:0]       warp_thread_cnt,
  output logic [NUM_WARPS-1:0]             warp_active,
  output logic [NUM_WARPS*XLEN-1:0]        warp_pc,
  output logic [NUM_WARPS-1:0]             warp_user,
  output logic                             err_thread_cnt,
  output logic                             err_warp_cnt
);
  import warp_ctl_pkg::*;

  logic              tmc_go, spawn_go, tmc_over, spawn_over;
  logic [CNT_W-1:0]  tmc_cnt;
  logic [SCNT_W-1:0] spawn_cnt;
  logic [NUM_WARPS-1:0] tmc_hit, spawn_hit;

  warp_cmd_dec #(
    .NUM_WARPS(NUM_WARPS), .NUM_THREADS(NUM_THREADS), .XLEN(XLEN)
  ) u_dec (
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op_e'(cmd_op)),
    .cmd_warp   (cmd_warp),
    .cmd_lane   (cmd_lane),
    .opa        (opa),
    .warp_active(warp_active),
    .tmc_go     (tmc_go),
    .spawn_go   (spawn_go),
    .tmc_cnt    (tmc_cnt),
    .spawn_cnt  (spawn_cnt),
    .tmc_over   (tmc_over),
    .spawn_over (spawn_over)
  );

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    assign tmc_hit[w]   = tmc_go && (cmd_warp == WID_W'(w));
    assign spawn_hit[w] = spawn_go && (w != 0) && (SCNT_W'(w) < spawn_cnt);

    warp_slot #(
      .NUM_THREADS(NUM_THREADS), .XLEN(XLEN),
      .BOOT(w == 0), .RESET_PC(RESET_PC)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .tmc_hit  (tmc_hit[w]),
      .spawn_hit(spawn_hit[w]),
      .tmc_cnt  (tmc_cnt),
      .spawn_pc (opb),
      .mask     (warp_mask[w*NUM_THREADS +: NUM_THREADS]),
      .cnt      (warp_thread_cnt[w*CNT_W +: CNT_W]),
      .active   (warp_active[w]),
      .pc       (warp_pc[w*XLEN +: XLEN]),
      .user     (warp_user[w])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_thread_cnt <= 1'b0;
      err_warp_cnt   <= 1'b0;
    end else begin
      err_thread_cnt <= tmc_go && tmc_over;
      err_warp_cnt   <= spawn_go && spawn_over;
    end
  end

  AST_WARP0_SPAWN_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_go |=> ($stable(warp_mask[NUM_THREADS-1:0]) && $stable(warp_pc[XLEN-1:0]))); // R6
  AST_THREAD_CLAMP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tmc_go && tmc_over) |=> err_thread_cnt); // R4
  AST_WARP_CLAMP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (spawn_go && spawn_over) |=> err_warp_cnt); // R7
  AST_NONZERO_LANE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_lane != '0) |=> ($stable(warp_mask) && $stable(warp_active)
                                       && !err_thread_cnt && !err_warp_cnt)); // R8
endmodule

// File: tb/warp_ctl_bench.sv
`timescale 1ns/1ps
module warp_ctl_bench;
  localparam int NW = 4;
  localparam int NT = 4;
  localparam int CW = 3;
  localparam logic [31:0] RPC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [1:0] cmd_warp = '0, cmd_lane = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [NW*NT-1:0] warp_mask;
  logic [NW*CW-1:0] warp_thread_cnt;
  logic [NW-1:0] warp_active, warp_user;
  logic [NW*32-1:0] warp_pc;
  logic err_thread_cnt, err_warp_cnt;

  always #2.5 clk = ~clk;

  warp_ctl #(.NUM_WARPS(NW), .NUM_THREADS(NT), .XLEN(32), .RESET_PC(RPC)) u_warp_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_warp(cmd_warp), .cmd_lane(cmd_lane), .opa(opa), .opb(opb),
    .warp_mask(warp_mask), .warp_thread_cnt(warp_thread_cnt),
    .warp_active(warp_active), .warp_pc(warp_pc), .warp_user(warp_user),
    .err_thread_cnt(err_thread_cnt), .err_warp_cnt(err_warp_cnt)
  );

  int n_checks = 0, n_fail = 0;
  int e_cnt[NW];
  bit e_act[NW], e_user[NW];
  logic [31:0] e_pc[NW];
  bit e_et, e_es;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    for (int w = 0; w < NW; w++) begin
      chk(req, $sformatf("mask w%0d", w), 32'(warp_mask[w*NT +: NT]), (32'd1 << e_cnt[w]) - 32'd1);
      chk(req, $sformatf("cnt w%0d", w), 32'(warp_thread_cnt[w*CW +: CW]), 32'(e_cnt[w]));
      chk(req, $sformatf("active w%0d", w), 32'(warp_active[w]), 32'(e_act[w]));
      chk(req, $sformatf("user w%0d", w), 32'(warp_user[w]), 32'(e_user[w]));
      chk(req, $sformatf("pc w%0d", w), warp_pc[w*32 +: 32], e_pc[w]);
    end
    chk(req, "err_thread_cnt", 32'(err_thread_cnt), 32'(e_et));
    chk(req, "err_warp_cnt", 32'(err_warp_cnt), 32'(e_es));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int w = 0; w < NW; w++) begin
      e_cnt[w] = (w == 0) ? 1 : 0;
      e_act[w] = (w == 0);
      e_user[w] = 1'b0;
      e_pc[w] = RPC;
    end
    e_et = 0; e_es = 0;
  endtask

  task automatic issue(bit op, int w, int lane, logic [31:0] a, logic [31:0] b, string req);
    bit ok;
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_warp = 2'(w); cmd_lane = 2'(lane);
    opa = a; opb = b;
    ok = (lane == 0) && e_act[w];
    e_et = 0; e_es = 0;
    if (ok && !op) begin
      n = (a > NT) ? NT : int'(a);
      e_et = (a > NT);
      e_cnt[w] = n;
      if (n == 0) e_act[w] = 0;
    end else if (ok && op) begin
      n = (a > NW) ? NW : int'(a);
      e_es = (a > NW);
      for (int k = 1; k < n; k++) begin
        e_cnt[k] = 1; e_act[k] = 1; e_user[k] = 1; e_pc[k] = b;
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    compare_all(req);
  endtask

  task automatic idle(int n, string req);
    repeat (n) @(negedge clk);
    e_et = 0; e_es = 0;
    compare_all(req);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    compare_all("R1");
    issue(1, 0, 0, 4, 32'h0000_4000, "R5");
    for (int n = 1; n <= NT; n++) issue(0, 2, 0, 32'(n), 0, "R2");
    issue(0, 2, 0, 7, 0, "R4");
    issue(0, 1, 0, 100, 0, "R4");
    idle(1, "R10");
    issue(0, 2, 1, 1, 0, "R8");
    issue(1, 2, 3, 4, 32'h0000_9000, "R8");
    issue(0, 3, 0, 0, 0, "R3");
    issue(0, 3, 0, 2, 0, "R9");
    issue(1, 3, 0, 4, 32'h0000_7000, "R9");
    idle(3, "R10");
    issue(0, 1, 0, 3, 0, "R2");
    issue(1, 1, 0, 2, 32'h0000_5000, "R6");
    issue(1, 0, 0, 9, 32'h0000_6000, "R7");
    idle(1, "R10");
    for (int n = 0; n <= NW + 2; n++) begin
      do_reset();
      issue(1, 0, 0, 32'(n), 32'h0000_2000 + 32'(n * 16), (n > NW) ? "R7" : "R6");
    end
    for (int n = 0; n <= NT + 1; n++) begin
      do_reset();
      issue(0, 0, 0, 32'(n), 0, (n == 0) ? "R3" : "R2");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule